// File: doc/BRIEF.md
# Clear-on-Read Interrupt Collector

This block gathers single-cycle event pulses from twelve subsystems of a power-management or audio controller into one sticky status register. It drives one active-high interrupt line to the host. When the line rises, the host reads the status register over a simple register port to find which subsystem raised it. That read also empties the register, so no separate acknowledge write is needed.

A second register holds one blocking bit per source. A blocked source still records its events in the status register, but it cannot drive the interrupt line. Every source comes out of reset blocked, so software has to enable the sources it wants. The status layout is sparse: fourteen bit positions carry twelve sources, and two positions stay empty in both registers.

Top module: `irq_collector`

## Requirements
- R1: After reset the status register reads 0x0000, the mask register reads 0x33FF (every implemented bit set) and `irq` is low.
- R2: The status register is at address 0x18 and the mask register is at address 0x20. A read of any other address returns 0.
- R3: Source inputs map to status bits as follows. Inputs 0 to 9 map to bits 0 to 9 in the same order: wakeup, USB, charger, system, RTC, ADC comparator, GPIO, codec, external, current sink. Input 10 (under-voltage) maps to bit 12. Input 11 (over-current) maps to bit 13.
- R4: A pulse on a source input sets its status bit whether or not the source is masked. The bit stays set until a status read clears it.
- R5: A read of the status register (`reg_re` high, address 0x18) returns the current value and clears every status bit at the next clock edge.
- R6: If an event arrives in the same cycle as a status read, the read returns the value from before the event, and the event's bit is set afterwards.
- R7: A write to address 0x18 does not change the status register.
- R8: A write to address 0x20 loads the mask from `reg_wdata` in bits 13, 12 and 9 to 0. Bits 10 and 11 read back as 0 in both registers.
- R9: A read of the mask register returns its value and changes neither register.
- R10: `irq` is registered. It goes high one cycle after any status bit is set while its mask bit is 0, and it goes low one cycle after no such bit remains.
- R11: While `reg_re` is low, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe, one cycle per read; a status read clears the status register |
| reg_wdata | input | 14 | Write data |
| reg_rdata | output | 14 | Read data, valid in the same cycle as `reg_re` |
| src_evt | input | 12 | One event pulse per source, high for one cycle per event |
| irq | output | 1 | Interrupt to the host, active high |

## Verification
The assertions assume the following about the inputs:
- Reset is held low from time zero until after the first clock edge.
- Each event lasts exactly one cycle.
- Register strobes change only away from the clock edge.

The bench drives every input on the falling edge, so nothing changes near a rising edge. It starts each run in reset. Events are single-cycle pulses, and they are placed so that the read-with-event and write-to-status cases are exercised both with and without an event in the same cycle. Under these conditions the sticky-hold and clear properties compare against a known state after each edge.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared sizes, register addresses and the source-to-bit placement for the
// interrupt collector. Assumes a 14-bit register layout with bits 10 and 11
// left empty.
package irqc_pkg;
    localparam int NUM_SRC  = 12;
    localparam int REG_W    = 14;
    localparam int ADDR_W   = 8;
    localparam int GAP_LO   = 10;
    localparam int GAP_W    = 2;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h18;
    localparam logic [ADDR_W-1:0] MASK_ADDR   = 8'h20;

    // Bit position in the status register for source k.
    function automatic int src_pos(input int k);
        return (k < GAP_LO) ? k : k + GAP_W;
    endfunction

    // Pattern of implemented register bits.
    function automatic logic [REG_W-1:0] impl_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            v[src_pos(k)] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [REG_W-1:0] IMPL = impl_bits();
endpackage

// File: rtl/irqc_spread.sv
// Module irqc_spread
// Places the dense per-source event vector into the sparse register layout.
// Purely combinational; empty bit positions are driven to 0.
module irqc_spread
    import irqc_pkg::*;
(
    input  logic [NUM_SRC-1:0] evt_dense,
    output logic [REG_W-1:0]   evt_sparse
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b < GAP_LO) begin : g_low
            // Bits below the gap take the source with the same index.
            assign evt_sparse[b] = evt_dense[b];
        end else if (b < GAP_LO + GAP_W) begin : g_gap
            // Bits in the gap have no source.
            assign evt_sparse[b] = 1'b0;
        end else begin : g_high
            // Bits above the gap take the source two indices lower.
            assign evt_sparse[b] = evt_dense[b - GAP_W];
        end
    end
endmodule

// File: rtl/irqc_status.sv
// Module irqc_status
// Sticky status register. A set pulse latches a bit; clr empties the register
// at the next edge. A set in the same cycle as clr wins for its own bit.
// Assumes set_vec is 0 outside the implemented bits.
module irqc_status
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic             clr,
    output logic [REG_W-1:0] status_q
);
    logic [REG_W-1:0] keep;

    // Bits kept from the previous cycle.
    always_comb keep = clr ? '0 : status_q;

    // Latch new events over the kept bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= keep | set_vec;
    end

    assert_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> status_q == '0);

    assert_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (status_q & $past(status_q)) == $past(status_q));

    assert_not_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec != '0) |=> status_q == $past(set_vec));
endmodule

// File: rtl/irqc_mask.sv
// Module irqc_mask
// Blocking register with one bit per source. Resets to all implemented bits
// set, and loads only the implemented bits on a write.
module irqc_mask
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q
);
    // Hold or load the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask_q <= IMPL;
        else if (wr) mask_q <= wdata & IMPL;
    end

    assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> mask_q == ($past(wdata) & IMPL));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> mask_q == $past(mask_q));
endmodule

// File: rtl/irq_collector.sv
// Module irq_collector
// First-level interrupt collector: sparse sticky status register with a
// clear-on-read side effect, a mask register, and a registered IRQ output.
// Assumes single-cycle strobes and event pulses.
module irq_collector
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic                 reg_re,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NUM_SRC-1:0]   src_evt,
    output logic                 irq
);
    logic             hit_status, hit_mask;
    logic             rd_status, wr_mask;
    logic [REG_W-1:0] evt_sparse, status_q, mask_q, pending;

    // Address decode.
    always_comb begin
        hit_status = (reg_addr == STATUS_ADDR);
        hit_mask   = (reg_addr == MASK_ADDR);
        rd_status  = reg_re && hit_status;
        wr_mask    = reg_we && hit_mask;
    end

    irqc_spread i_spread (
        .evt_dense  (src_evt),
        .evt_sparse (evt_sparse)
    );

    irqc_status i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (evt_sparse),
        .clr      (rd_status),
        .status_q (status_q)
    );

    irqc_mask i_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_mask),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    // Read mux: returns pre-edge register contents.
    always_comb begin
        reg_rdata = '0;
        if (reg_re && hit_status)    reg_rdata = status_q;
        else if (reg_re && hit_mask) reg_rdata = mask_q;
    end

    // Unmasked pending sources.
    always_comb pending = status_q & ~mask_q;

    // Register the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pending;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_q == '0 && mask_q == IMPL && !irq));

    assert_other_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && !hit_status && !hit_mask) |-> reg_rdata == '0);

    assert_status_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_status && !reg_re && src_evt == '0) |=> status_q == $past(status_q));

    assert_gap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> reg_rdata[GAP_LO+GAP_W-1:GAP_LO] == '0);

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_q) == IMPL) |-> !irq);

    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |-> reg_rdata == '0);
endmodule

// File: tb/test_irq_collector.sv
`timescale 1ns/1ps
module test_irq_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [13:0] reg_wdata = '0;
    logic [13:0] reg_rdata;
    logic [11:0] src_evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Reference state
    logic [13:0] m_status = '0;
    logic [13:0] m_mask = 14'h33FF;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_collector i_irq_collector (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .src_evt(src_evt), .irq(irq)
    );

    function automatic logic [13:0] place(input logic [11:0] ev);
        logic [13:0] v = '0;
        for (int k = 0; k < 12; k++)
            if (ev[k]) v[(k < 10) ? k : k + 2] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare outputs, advance the model.
    task automatic step(input logic [11:0] ev, input logic [7:0] a,
                        input logic w, input logic r, input logic [13:0] d,
                        input string tag);
        logic [13:0] exp_rd;
        @(negedge clk);
        src_evt = ev; reg_addr = a; reg_we = w; reg_re = r; reg_wdata = d;
        #1;
        exp_rd = '0;
        if (r && a == 8'h18) exp_rd = m_status;
        else if (r && a == 8'h20) exp_rd = m_mask;
        check(tag, "rdata", reg_rdata, exp_rd);
        check(tag, "irq", {13'b0, irq}, {13'b0, m_irq});
        @(posedge clk);
        m_irq = |(m_status & ~m_mask);
        m_status = ((r && a == 8'h18) ? 14'h0 : m_status) | place(ev);
        if (w && a == 8'h20) m_mask = d & 14'h33FF;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step('0, 8'h00, 1'b0, 1'b0, '0, tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        step('0, 8'h20, 0, 1, '0, "R1");
        step('0, 8'h18, 0, 1, '0, "R1");
        // R2: unmapped address; R11: no strobe
        step('0, 8'h00, 0, 1, '0, "R2");
        step('0, 8'h19, 0, 1, '0, "R2");
        step(12'h001, 8'h18, 0, 0, '0, "R11");
        // R4: masked source still latches, irq stays low (R10)
        idle(2, "R4");
        step('0, 8'h18, 0, 1, '0, "R4");
        // R5: cleared by the read
        step('0, 8'h18, 0, 1, '0, "R5");
        // R8: mask write, gap bits dropped
        step('0, 8'h20, 1, 0, 14'h3FFF, "R8");
        step('0, 8'h20, 0, 1, '0, "R8");
        step('0, 8'h20, 1, 0, 14'h0000, "R8");
        step('0, 8'h20, 0, 1, '0, "R8");
        // R3 + R10: each source alone, unmasked
        for (int k = 0; k < 12; k++) begin
            step(12'(1 << k), 8'h00, 0, 0, '0, "R3");
            idle(2, "R10");
            step('0, 8'h18, 0, 1, '0, "R3");
            idle(2, "R10");
        end
        // R6: event during a status read
        step(12'h800, 8'h00, 0, 0, '0, "R6");
        step(12'h004, 8'h18, 0, 1, '0, "R6");
        step('0, 8'h18, 0, 1, '0, "R6");
        step('0, 8'h18, 0, 1, '0, "R6");
        // R7: status write is ignored
        step(12'h0A5, 8'h00, 0, 0, '0, "R7");
        step('0, 8'h18, 1, 0, 14'h0000, "R7");
        step(12'h400, 8'h18, 1, 0, 14'h3FFF, "R7");
        step('0, 8'h18, 0, 1, '0, "R7");
        // R9: mask read has no side effect
        step(12'h030, 8'h00, 0, 0, '0, "R9");
        step('0, 8'h20, 0, 1, '0, "R9");
        step('0, 8'h20, 0, 1, '0, "R9");
        step('0, 8'h18, 0, 1, '0, "R9");
        // R10: masking a pending source drops irq, unmasking raises it
        step(12'h002, 8'h00, 0, 0, '0, "R10");
        idle(1, "R10");
        step('0, 8'h20, 1, 0, 14'h0002, "R10");
        idle(2, "R10");
        step('0, 8'h20, 1, 0, 14'h0000, "R10");
        idle(2, "R10");
        step('0, 8'h18, 0, 1, '0, "R10");
        idle(2, "R10");
        // Burst of mixed events, then one read
        step(12'h111, 8'h00, 0, 0, '0, "R4");
        step(12'hC00, 8'h00, 0, 0, '0, "R4");
        step(12'h2AA, 8'h20, 0, 1, '0, "R4");
        step('0, 8'h18, 0, 1, '0, "R5");
        idle(2, "R5");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule